// File: doc/BRIEF.md
# Read-Coherent Byte-Sliced Result Register

This block holds the latest 24-bit sample from a producer, such as a converter, and presents it to a bus master that can only fetch one byte per access. The master picks a byte with a 2-bit address and pulses a read strobe. Reading any sample byte freezes the visible value. The value stays frozen until the master reads the byte chosen as the key byte. This way the three bytes of one multi-byte read always come from the same sample, whatever order the bytes are fetched in.

Samples that arrive during a freeze are not lost. They are kept in a one-deep pending slot, and a later arrival overwrites the slot. The pending sample moves into the visible register on the first free clock edge. A sticky overrun flag records that a sample was discarded before anyone could see it. Address 3 returns a status byte, and reading that byte clears the overrun flag. A 2-bit configuration input selects the key byte: the low, middle or high byte. The key choice is only taken up while no freeze is in progress.

Top module: `coh_result_reg`

## Requirements
- R1: After reset the visible sample is zero, `locked`, `pend_valid` and `overrun` are low, and the key byte is the low byte.
- R2: `rd_data` is combinational from `rd_addr`. Address 0 gives bits 7:0, address 1 gives bits 15:8 and address 2 gives bits 23:16 of the visible sample.
- R3: At a clock edge where the register is neither locked nor being locked, a sample with `smp_valid` high becomes the visible sample.
- R4: A strobed read of address 0, 1 or 2 that is not the key byte sets `locked` at that edge. While `locked` is high, the visible sample does not change.
- R5: A strobed read of the key byte leaves `locked` low after that edge. If the key byte is read while unlocked, no freeze results, and a sample arriving at that same edge is accepted directly.
- R6: The `key_sel` codes are 0 = low byte, 1 = middle byte, and 2 or 3 = high byte. The key is taken up at every edge where `locked` is low, and it is held unchanged while `locked` is high.
- R7: A sample arriving at an edge where the register is locked, or is being locked by a non-key read, is stored in the pending slot. `pend_valid` then goes high, and a later such sample replaces the stored one.
- R8: The pending sample becomes visible at the first edge that is neither locked nor locking. If a new sample arrives at that edge, the new sample wins and the pending one is dropped.
- R9: `overrun` goes high whenever a pending sample is discarded undelivered, which happens whenever a sample arrives while `pend_valid` is high. It stays high until a strobed read of address 3. A discard at the same edge as that read wins, so the flag stays set.
- R10: Address 3 returns the status byte {zeros, overrun (bit 2), pend_valid (bit 1), locked (bit 0)}. Reading address 3 never changes the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample strobe from the producer |
| smp_data | input | 24 | New sample value |
| rd_en | input | 1 | Byte read strobe from the bus master |
| rd_addr | input | 2 | Byte address: 0 low, 1 middle, 2 high, 3 status |
| key_sel | input | 2 | Key byte selection code |
| rd_data | output | 8 | Byte selected by rd_addr |
| locked | output | 1 | Visible sample frozen |
| pend_valid | output | 1 | Pending slot holds an undelivered sample |
| overrun | output | 1 | Sticky flag for a discarded sample |

## Verification
A wrong lock state shows up first in `locked` and bit 0 of the status byte, one edge after the read that caused it. It then shows up in a data byte at the first sample that should have been frozen or accepted. A stale or lost pending slot shows in `pend_valid` at the next edge, and in the visible bytes at the first free edge after unlock. A wrong key register shows as a read that fails to release the lock, or releases it too early, and this is visible on `locked` one edge later. The bench compares every output against its model on every cycle, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/coh_pkg.sv
package coh_pkg;

    localparam int unsigned LANE_W_DEF    = 8;
    localparam int unsigned NUM_LANES_DEF = 3;
    localparam int unsigned ADDR_W        = 2;

    // Byte lane addresses; the status byte sits above the sample lanes.
    typedef enum logic [ADDR_W-1:0] {
        LANE_LO   = 2'd0,
        LANE_MID  = 2'd1,
        LANE_HI   = 2'd2,
        LANE_STAT = 2'd3
    } lane_e;

    // Status byte layout, LSB = lock.
    typedef struct packed {
        logic overrun;
        logic pend;
        logic locked;
    } stat_t;

    // Per-access decode shared between the lock and store logic.
    typedef struct packed {
        logic lane_rd;
        logic key_hit;
        logic stat_rd;
    } access_t;

    // Reserved code 3 behaves as the high byte.
    function automatic lane_e decode_key(input logic [ADDR_W-1:0] raw);
        lane_e k;
        if (raw == 2'd3) k = LANE_HI;
        else             k = lane_e'(raw);
        return k;
    endfunction

endpackage

// File: rtl/coh_lock_ctrl.sv
module coh_lock_ctrl
    import coh_pkg::*;
#(
    parameter int unsigned NUM_LANES = NUM_LANES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] key_sel,
    output logic              locked,
    output logic              blocked,
    output access_t           acc,
    output lane_e             key_q
);

    localparam logic [ADDR_W-1:0] LAST_LANE = ADDR_W'(NUM_LANES - 1);

    logic locked_q;

    always_comb begin
        acc.lane_rd = rd_en && (rd_addr <= LAST_LANE);
        acc.key_hit = acc.lane_rd && (rd_addr == logic'(1'b0) ? (key_q == LANE_LO)
                                                              : (rd_addr == key_q));
        acc.stat_rd = rd_en && (rd_addr == LANE_STAT);
        // Frozen now, or frozen starting at this edge by a non-key read.
        blocked     = locked_q || (acc.lane_rd && !acc.key_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
            key_q    <= LANE_LO;
        end else begin
            if (acc.lane_rd) begin
                locked_q <= !acc.key_hit;
            end
            if (!locked_q) begin
                key_q <= decode_key(key_sel);
            end
        end
    end

    assign locked = locked_q;

endmodule

// File: rtl/coh_sample_store.sv
module coh_sample_store #(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blocked,
    input  logic              stat_rd,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] vis,
    output logic              pend_valid,
    output logic              overrun
);

    logic [DATA_W-1:0] vis_q;
    logic [DATA_W-1:0] pend_q;
    logic              pv_q;
    logic              ovr_q;
    logic              drop;

    // Any arrival while the slot is occupied discards the slot's sample.
    assign drop = smp_valid && pv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q  <= '0;
            pend_q <= '0;
            pv_q   <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (blocked) begin
                if (smp_valid) begin
                    pend_q <= smp_data;
                    pv_q   <= 1'b1;
                end
            end else if (smp_valid) begin
                vis_q <= smp_data;
                pv_q  <= 1'b0;
            end else if (pv_q) begin
                vis_q <= pend_q;
                pv_q  <= 1'b0;
            end

            if (drop)         ovr_q <= 1'b1;
            else if (stat_rd) ovr_q <= 1'b0;
        end
    end

    assign vis        = vis_q;
    assign pend_valid = pv_q;
    assign overrun    = ovr_q;

endmodule

// File: rtl/coh_read_mux.sv
module coh_read_mux
    import coh_pkg::*;
#(
    parameter int unsigned LANE_W    = LANE_W_DEF,
    parameter int unsigned NUM_LANES = NUM_LANES_DEF
) (
    input  logic [NUM_LANES*LANE_W-1:0] vis,
    input  stat_t                       stat,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [LANE_W-1:0]           rd_data
);

    localparam int unsigned SLOTS = 1 << ADDR_W;

    logic [LANE_W-1:0] slot [SLOTS];

    for (genvar g = 0; g < SLOTS - 1; g++) begin : g_slot
        if (g < NUM_LANES) begin : g_lane
            assign slot[g] = vis[g*LANE_W +: LANE_W];
        end else begin : g_empty
            assign slot[g] = '0;
        end
    end

    assign slot[SLOTS-1] = LANE_W'(stat);
    assign rd_data       = slot[rd_addr];

endmodule

// File: rtl/coh_result_reg.sv
module coh_result_reg
    import coh_pkg::*;
#(
    parameter int unsigned LANE_W    = LANE_W_DEF,
    parameter int unsigned NUM_LANES = NUM_LANES_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        smp_valid,
    input  logic [NUM_LANES*LANE_W-1:0] smp_data,
    input  logic                        rd_en,
    input  logic [1:0]                  rd_addr,
    input  logic [1:0]                  key_sel,
    output logic [LANE_W-1:0]           rd_data,
    output logic                        locked,
    output logic                        pend_valid,
    output logic                        overrun
);

    localparam int unsigned DATA_W = NUM_LANES * LANE_W;

    logic              blocked;
    access_t           acc;
    lane_e             key_q;
    logic [DATA_W-1:0] vis_q;
    stat_t             stat;

    coh_lock_ctrl #(.NUM_LANES(NUM_LANES)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .key_sel (key_sel),
        .locked  (locked),
        .blocked (blocked),
        .acc     (acc),
        .key_q   (key_q)
    );

    coh_sample_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .blocked    (blocked),
        .stat_rd    (acc.stat_rd),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .vis        (vis_q),
        .pend_valid (pend_valid),
        .overrun    (overrun)
    );

    assign stat.overrun = overrun;
    assign stat.pend    = pend_valid;
    assign stat.locked  = locked;

    coh_read_mux #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_mux (
        .vis     (vis_q),
        .stat    (stat),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/coh_result_reg_chk.sv
module coh_result_reg_chk #(
    parameter int unsigned DATA_W    = 24,
    parameter int unsigned NUM_LANES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [1:0]        rd_addr,
    input logic              smp_valid,
    input logic              locked,
    input logic              pend_valid,
    input logic              overrun,
    input logic              blocked,
    input logic [1:0]        key_q,
    input logic [DATA_W-1:0] vis
);

    localparam logic [1:0] LAST_LANE = 2'(NUM_LANES - 1);

    AST_FROZEN_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(vis)); // R4

    AST_LOCK_ON_NONKEY: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr <= LAST_LANE && rd_addr != key_q) |=> locked); // R4

    AST_KEY_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == key_q) |=> !locked); // R5

    AST_KEY_HELD: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(key_q)); // R6

    AST_KEY_NOT_RESERVED: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(key_q) |-> key_q != 2'd3); // R6

    AST_PEND_NEEDS_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (!pend_valid && !(blocked && smp_valid)) |=> !pend_valid); // R7

    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && !blocked) |=> !pend_valid); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !(rd_en && rd_addr == 2'd3)) |=> overrun); // R9

    AST_STATUS_READ_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!locked && rd_en && rd_addr == 2'd3) |=> !locked); // R10

endmodule

bind coh_result_reg coh_result_reg_chk #(
    .DATA_W    (NUM_LANES * LANE_W),
    .NUM_LANES (NUM_LANES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .smp_valid  (smp_valid),
    .locked     (locked),
    .pend_valid (pend_valid),
    .overrun    (overrun),
    .blocked    (blocked),
    .key_q      (key_q),
    .vis        (vis_q)
);

// File: tb/tb_coh_result_reg.sv
`timescale 1ns/1ps
module tb_coh_result_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [1:0]  key_sel = '0;
    logic [7:0]  rd_data;
    logic        locked, pend_valid, overrun;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // Behavioural reference state
    int m_vis = 0, m_pend = 0, m_pv = 0, m_lock = 0, m_key = 0, m_ovr = 0;

    always #2 clk = ~clk;

    coh_result_reg dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .key_sel(key_sel),
        .rd_data(rd_data), .locked(locked), .pend_valid(pend_valid), .overrun(overrun)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_byte(input int a);
        if (a == 3) return (m_ovr << 2) | (m_pv << 1) | m_lock;
        return (m_vis >> (8 * a)) & 8'hFF;
    endfunction

    // Drive one cycle of inputs, compare outputs before the edge, then advance the model.
    task automatic step(input bit v, input int d, input bit re, input int a, input int k,
                        input string tag);
        int lane_rd, blk, drop;
        smp_valid = v; smp_data = d[23:0]; rd_en = re; rd_addr = a[1:0]; key_sel = k[1:0];
        #1;
        check(tag, "rd_data", int'(rd_data), exp_byte(a));
        check(tag, "locked", int'(locked), m_lock);
        check(tag, "pend_valid", int'(pend_valid), m_pv);
        check(tag, "overrun", int'(overrun), m_ovr);
        @(posedge clk);
        lane_rd = re && (a < 3);
        blk     = m_lock || (lane_rd && a != m_key);
        drop    = v && m_pv;
        if (lane_rd) m_lock = (a != m_key);
        if (!blk && lane_rd == 0 && m_lock == 0) ; // no change
        if (blk) begin
            if (v) begin m_pend = d & 24'hFFFFFF; m_pv = 1; end
        end else if (v) begin
            m_vis = d & 24'hFFFFFF; m_pv = 0;
        end else if (m_pv) begin
            m_vis = m_pend; m_pv = 0;
        end
        if (drop) m_ovr = 1;
        else if (re && a == 3) m_ovr = 0;
        @(negedge clk);
    endtask

    // Key register follows key_sel whenever the pre-edge lock is low.
    always @(posedge clk) begin
        if (rst) m_key <= 0;
        else if (!locked) m_key <= (key_sel == 2'd3) ? 2 : int'(key_sel);
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state at every address
        for (int a = 0; a < 4; a++) step(0, 0, 0, a, 0, "R1");

        // R3: samples while free update immediately
        step(1, 24'hA1B2C3, 0, 0, 0, "R3");
        step(1, 24'h102030, 0, 1, 0, "R3");
        step(0, 0, 0, 2, 0, "R3");

        // R2: read bytes 1,2 (locks), then key 0 releases
        step(0, 0, 1, 1, 0, "R2");
        step(0, 0, 1, 2, 0, "R2");
        step(0, 0, 1, 0, 0, "R2");
        step(0, 0, 0, 0, 0, "R2");

        // R4 / R7 / R9: lock, two arrivals, overrun, visible frozen
        step(1, 24'h111111, 1, 2, 0, "R4");
        step(0, 0, 0, 2, 0, "R4");
        step(1, 24'h222222, 0, 1, 0, "R7");
        step(0, 0, 0, 3, 0, "R9");
        // R10: status read does not unlock, and clears overrun
        step(0, 0, 1, 3, 0, "R10");
        step(0, 0, 0, 3, 0, "R10");
        // R8: release with key, pending delivered next edge
        step(0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 2, 0, "R8");

        // R5: key-first read with same-edge sample is accepted, no lock
        step(1, 24'h5A5A5A, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R5");

        // R8: pending and new sample at first free edge, new wins, overrun
        step(1, 24'h333333, 1, 1, 0, "R8");
        step(0, 0, 1, 0, 0, "R8");
        step(1, 24'h444444, 0, 2, 0, "R8");
        step(0, 0, 0, 3, 0, "R9");
        step(1, 24'h454545, 1, 3, 0, "R9");
        step(0, 0, 1, 3, 0, "R9");

        // R6: key codes 2 and 3 select high byte
        step(0, 0, 0, 0, 2, "R6");
        step(0, 0, 1, 0, 2, "R6");
        step(0, 0, 1, 2, 2, "R6");
        step(0, 0, 0, 0, 3, "R6");
        step(0, 0, 1, 1, 3, "R6");
        step(0, 0, 1, 2, 3, "R6");
        // R6: key change while locked is ignored until release
        step(0, 0, 1, 0, 1, "R6");
        step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 1, 1, 0, "R6");
        step(0, 0, 1, 2, 0, "R6");
        step(0, 0, 1, 1, 0, "R6");
        step(0, 0, 0, 0, 0, "R6");

        // Mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit v  = ($urandom % 3) == 0;
            bit re = ($urandom % 2) == 0;
            int a  = int'($urandom % 4);
            int k  = (($urandom % 16) == 0) ? int'($urandom % 4) : int'(key_sel);
            step(v, int'($urandom & 32'hFFFFFF), re, a, k, "R8");
        end

        summary();
        $finish;
    end

endmodule